// File: doc/BRIEF.md
# Two-Slot Bundle Execution Core

This block is a small in-order core that runs a 32-bit load/store instruction subset. Each program word is a 64-bit bundle that carries two instructions. Every cycle the core fetches one bundle from its internal program store, decodes both halves and issues them together in lock-step. The upper half is the compute slot. It accepts register-register ALU operations, add-immediate and the two conditional branches. The lower half is the memory slot, and it accepts only word loads and word stores. A slot that holds anything else does nothing. A four-read, two-write register file serves both slots in the same cycle. The main ALU works on the compute slot. A separate adder forms the memory slot's address, so the two never compete for one unit.

The core has no interlocks. Code must be scheduled ahead of time so that a loaded value is used no sooner than two bundles after its load. The program store and the data memory are filled through host ports while reset is held low. The host can read any register and any data word at any time. The fetch address is visible on an output port, so a caller can measure how many cycles a program takes.

Top module: `duo_slot_core`

## Requirements
- R1: While `rst_n` is low, `pc_o` reads 0 and every register reads 0 through the host register port.
- R2: Without a taken branch, `pc_o` rises by exactly 8 on each clock edge and stays a multiple of 8. The compute instruction sits in bundle bits 63:32 and the memory instruction in bits 31:0, and the two are issued in the same cycle.
- R3: Compute-slot encodings use opcode in bits 31:26, rs 25:21, rt 20:16, rd 15:11 and funct 5:0. Opcode 0 with funct 0x21 adds, 0x23 subtracts, 0x24 ANDs, 0x25 ORs, and 0x2A writes 1 if rs < rt as signed numbers, else 0. Opcode 0x08 writes rs plus the sign-extended 16-bit immediate to rt.
- R4: Compute-slot opcode 0x04 (equal) and 0x05 (not equal) compare rs with rt. When the branch is taken, the next fetch is at PC+8 plus the sign-extended immediate shifted left by 3. The bundles in between are never executed.
- R5: The memory instruction in the same bundle as a taken branch still completes.
- R6: Memory-slot opcode 0x23 loads and opcode 0x2B stores a 32-bit word. The byte address is rs plus the sign-extended immediate, formed without the ALU, and it selects word address/4. A load writes rt.
- R7: A loaded value can be read by the bundle two after the load. The bundle right after the load still sees the register's old value.
- R8: An unsupported opcode or funct, or a valid operation placed in the wrong slot, changes no register and no memory word.
- R9: Writes to register 0 are dropped, and register 0 always reads 0.
- R10: When a load result and a compute result target the same register in the same cycle, the load result is kept.
- R11: Host writes to program and data memory take effect only while `rst_n` is low.
- R12: A scheduled array-add loop leaves the memory contents and the cycle count that an independent model predicts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; host load window |
| imem_we | input | 1 | Program store write strobe (honoured in reset) |
| imem_addr | input | IA_W | Bundle index to write |
| imem_wdata | input | 2*XLEN | Bundle to write |
| host_dm_we | input | 1 | Data memory write strobe (honoured in reset) |
| host_dm_addr | input | DA_W | Data word index for host write and read |
| host_dm_wdata | input | XLEN | Data word to write |
| host_dm_rdata | output | XLEN | Data word at `host_dm_addr` |
| host_rf_addr | input | 5 | Register to observe |
| host_rf_rdata | output | XLEN | Value of register `host_rf_addr` |
| pc_o | output | XLEN | Byte address of the bundle being executed |

## Verification
The assertions check the fetch sequence on every cycle. The address advances by 8 unless a branch is taken, a taken branch lands exactly on its computed target, and the address stays aligned. They also check that every load issue produces a writeback one cycle later, and that register 0 never reads as anything but zero. Only the bench scenarios can show the values that matter: the arithmetic results, which bundles a branch skips, the stale value seen one bundle after a load, the priority of a load over a same-cycle compute write, that misplaced or unknown instructions change nothing, and the cycle count and final array of the scheduled loop.

// File: rtl/duo_pkg.sv
package duo_pkg;

   localparam logic [5:0] OPC_RTYPE = 6'h00;
   localparam logic [5:0] OPC_ADDI  = 6'h08;
   localparam logic [5:0] OPC_BEQ   = 6'h04;
   localparam logic [5:0] OPC_BNE   = 6'h05;
   localparam logic [5:0] OPC_LW    = 6'h23;
   localparam logic [5:0] OPC_SW    = 6'h2B;

   localparam logic [5:0] FN_ADDU = 6'h21;
   localparam logic [5:0] FN_SUBU = 6'h23;
   localparam logic [5:0] FN_AND  = 6'h24;
   localparam logic [5:0] FN_OR   = 6'h25;
   localparam logic [5:0] FN_SLT  = 6'h2A;

   typedef enum logic [2:0] {
      ALU_ADD,
      ALU_SUB,
      ALU_AND,
      ALU_OR,
      ALU_SLT
   } alu_op_e;

   typedef struct packed {
      logic        wr_en;
      logic [4:0]  rd;
      logic [4:0]  rs;
      logic [4:0]  rt;
      alu_op_e     op;
      logic        use_imm;
      logic        is_br;
      logic        br_ne;
      logic [15:0] imm;
   } cmp_dec_t;

   typedef struct packed {
      logic        is_ld;
      logic        is_st;
      logic [4:0]  rs;
      logic [4:0]  rt;
      logic [15:0] imm;
   } mem_dec_t;

   // compute slot: R-type ALU ops, add-immediate, branches; all else inert
   function automatic cmp_dec_t dec_cmp(input logic [31:0] ins);
      cmp_dec_t d;
      d     = '0;
      d.rs  = ins[25:21];
      d.rt  = ins[20:16];
      d.imm = ins[15:0];
      d.op  = ALU_ADD;
      case (ins[31:26])
         OPC_RTYPE: begin
            d.rd    = ins[15:11];
            d.wr_en = 1'b1;
            case (ins[5:0])
               FN_ADDU: d.op = ALU_ADD;
               FN_SUBU: d.op = ALU_SUB;
               FN_AND:  d.op = ALU_AND;
               FN_OR:   d.op = ALU_OR;
               FN_SLT:  d.op = ALU_SLT;
               default: d.wr_en = 1'b0;
            endcase
         end
         OPC_ADDI: begin
            d.rd      = ins[20:16];
            d.wr_en   = 1'b1;
            d.use_imm = 1'b1;
         end
         OPC_BEQ: d.is_br = 1'b1;
         OPC_BNE: begin
            d.is_br = 1'b1;
            d.br_ne = 1'b1;
         end
         default: d.wr_en = 1'b0;
      endcase
      return d;
   endfunction

   // memory slot: word load and store only
   function automatic mem_dec_t dec_mem(input logic [31:0] ins);
      mem_dec_t d;
      d       = '0;
      d.rs    = ins[25:21];
      d.rt    = ins[20:16];
      d.imm   = ins[15:0];
      d.is_ld = (ins[31:26] == OPC_LW);
      d.is_st = (ins[31:26] == OPC_SW);
      return d;
   endfunction

endpackage

// File: rtl/duo_regfile.sv
module duo_regfile #(
   parameter int W    = 32,
   parameter int NREG = 32,
   parameter int NRD  = 4,
   parameter int NWR  = 2,
   localparam int RA_W = $clog2(NREG)
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic [NRD-1:0][RA_W-1:0]  ra,
   output logic [NRD-1:0][W-1:0]     rdata,
   input  logic [NWR-1:0]            we,
   input  logic [NWR-1:0][RA_W-1:0]  wa,
   input  logic [NWR-1:0][W-1:0]     wd
);
   timeunit 1ns;
   timeprecision 1ps;

   logic [W-1:0] q [NREG];

   // higher-numbered write port is applied last and therefore wins
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < NREG; i++) q[i] <= '0;
      end else begin
         for (int p = 0; p < NWR; p++) begin
            if (we[p] && (wa[p] != '0)) q[wa[p]] <= wd[p];
         end
      end
   end

   for (genvar r = 0; r < NRD; r++) begin : g_rd
      assign rdata[r] = q[ra[r]];
   end

endmodule

// File: rtl/duo_alu.sv
module duo_alu import duo_pkg::*; #(
   parameter int W = 32
) (
   input  logic [W-1:0] a,
   input  logic [W-1:0] b,
   input  alu_op_e      op,
   output logic [W-1:0] y,
   output logic         eq
);
   timeunit 1ns;
   timeprecision 1ps;

   always_comb begin
      case (op)
         ALU_ADD: y = a + b;
         ALU_SUB: y = a - b;
         ALU_AND: y = a & b;
         ALU_OR:  y = a | b;
         ALU_SLT: y = {{(W-1){1'b0}}, ($signed(a) < $signed(b))};
         default: y = '0;
      endcase
   end

   assign eq = (a == b);

endmodule

// File: rtl/duo_agu.sv
module duo_agu #(
   parameter int W = 32
) (
   input  logic [W-1:0] base,
   input  logic [15:0]  off,
   output logic [W-1:0] addr
);
   timeunit 1ns;
   timeprecision 1ps;

   assign addr = base + {{(W-16){off[15]}}, off};

endmodule

// File: rtl/duo_slot_core.sv
module duo_slot_core import duo_pkg::*; #(
   parameter int XLEN       = 32,
   parameter int IMEM_DEPTH = 64,
   parameter int DMEM_DEPTH = 64,
   localparam int IA_W = $clog2(IMEM_DEPTH),
   localparam int DA_W = $clog2(DMEM_DEPTH)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              imem_we,
   input  logic [IA_W-1:0]   imem_addr,
   input  logic [2*XLEN-1:0] imem_wdata,
   input  logic              host_dm_we,
   input  logic [DA_W-1:0]   host_dm_addr,
   input  logic [XLEN-1:0]   host_dm_wdata,
   output logic [XLEN-1:0]   host_dm_rdata,
   input  logic [4:0]        host_rf_addr,
   output logic [XLEN-1:0]   host_rf_rdata,
   output logic [XLEN-1:0]   pc_o
);
   timeunit 1ns;
   timeprecision 1ps;

   localparam int BW    = 2 * XLEN;
   localparam int NREG  = 32;
   localparam int NRD   = 5;   // two per slot plus host observation
   localparam int NWR   = 2;   // port 0 compute, port 1 load (wins)
   localparam int STEP  = 8;

   if (XLEN != 32) begin : g_bad_xlen
      $error("duo_slot_core: XLEN must be 32");
   end
   if (IMEM_DEPTH < 2 || (IMEM_DEPTH & (IMEM_DEPTH - 1)) != 0) begin : g_bad_imem
      $error("duo_slot_core: IMEM_DEPTH must be a power of two >= 2");
   end
   if (DMEM_DEPTH < 2 || (DMEM_DEPTH & (DMEM_DEPTH - 1)) != 0 || DA_W + 2 > XLEN - 1) begin : g_bad_dmem
      $error("duo_slot_core: DMEM_DEPTH must be a power of two within address range");
   end

   logic [BW-1:0]   imem [IMEM_DEPTH];
   logic [XLEN-1:0] dmem [DMEM_DEPTH];

   logic [XLEN-1:0] pc_q, pc_seq, br_target, alu_b, alu_y, mem_addr, ld_data_q;
   logic [BW-1:0]   bundle;
   cmp_dec_t        d0;
   mem_dec_t        d1;
   logic            alu_eq, br_taken, ld_go, st_go, ld_pend_q;
   logic [4:0]      ld_rd_q;
   logic [DA_W-1:0] dm_idx;

   logic [NRD-1:0][4:0]      rf_ra;
   logic [NRD-1:0][XLEN-1:0] rf_rd;
   logic [NWR-1:0]           rf_we;
   logic [NWR-1:0][4:0]      rf_wa;
   logic [NWR-1:0][XLEN-1:0] rf_wd;

   // fetch and lock-step decode of both slots
   assign bundle = imem[pc_q[IA_W+2:3]];
   assign d0     = dec_cmp(bundle[BW-1 -: XLEN]);
   assign d1     = dec_mem(bundle[XLEN-1:0]);

   assign rf_ra = {host_rf_addr, d1.rt, d1.rs, d0.rt, d0.rs};

   duo_regfile #(.W(XLEN), .NREG(NREG), .NRD(NRD), .NWR(NWR)) u_rf (
      .clk   (clk),
      .rst_n (rst_n),
      .ra    (rf_ra),
      .rdata (rf_rd),
      .we    (rf_we),
      .wa    (rf_wa),
      .wd    (rf_wd)
   );

   // compute slot
   assign alu_b = d0.use_imm ? {{(XLEN-16){d0.imm[15]}}, d0.imm} : rf_rd[1];

   duo_alu #(.W(XLEN)) u_alu (
      .a  (rf_rd[0]),
      .b  (alu_b),
      .op (d0.op),
      .y  (alu_y),
      .eq (alu_eq)
   );

   assign br_taken  = d0.is_br & (alu_eq ^ d0.br_ne);
   assign pc_seq    = pc_q + XLEN'(STEP);
   assign br_target = pc_seq + {{(XLEN-19){d0.imm[15]}}, d0.imm, 3'b000};

   // memory slot with its own address adder
   duo_agu #(.W(XLEN)) u_agu (
      .base (rf_rd[2]),
      .off  (d1.imm),
      .addr (mem_addr)
   );

   assign ld_go  = d1.is_ld;
   assign st_go  = d1.is_st;
   assign dm_idx = mem_addr[DA_W+1:2];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         if (imem_we) imem[imem_addr] <= imem_wdata;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         if (host_dm_we) dmem[host_dm_addr] <= host_dm_wdata;
      end else if (st_go) begin
         dmem[dm_idx] <= rf_rd[3];
      end
      ld_data_q <= dmem[dm_idx];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pc_q      <= '0;
         ld_pend_q <= 1'b0;
         ld_rd_q   <= '0;
      end else begin
         pc_q      <= br_taken ? br_target : pc_seq;
         ld_pend_q <= ld_go;
         ld_rd_q   <= d1.rt;
      end
   end

   // writeback: compute result now, load result one cycle later
   assign rf_we = {ld_pend_q, d0.wr_en};
   assign rf_wa = {ld_rd_q, d0.rd};
   assign rf_wd = {ld_data_q, alu_y};

   assign host_dm_rdata = dmem[host_dm_addr];
   assign host_rf_rdata = rf_rd[4];
   assign pc_o          = pc_q;

   logic unused_bits;
   assign unused_bits = ^{mem_addr[XLEN-1:DA_W+2], mem_addr[1:0]};

endmodule

module duo_slot_core_chk #(
   parameter int W = 32
) (
   input logic         clk,
   input logic         rst_n,
   input logic [W-1:0] pc,
   input logic         br_taken,
   input logic [W-1:0] br_target,
   input logic         ld_go,
   input logic         ld_pend,
   input logic [4:0]   probe_addr,
   input logic [W-1:0] probe_data
);
   timeunit 1ns;
   timeprecision 1ps;

   AST_PC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      !br_taken |=> (pc == $past(pc) + W'(8)));  // R2
   AST_PC_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
      pc[2:0] == 3'b000);  // R2
   AST_BR_REDIRECT: assert property (@(posedge clk) disable iff (!rst_n)
      br_taken |=> (pc == $past(br_target)));  // R4
   AST_LOAD_WB_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
      ld_go |=> ld_pend);  // R7
   AST_ZERO_REG: assert property (@(posedge clk) disable iff (!rst_n)
      (probe_addr == 5'd0) |-> (probe_data == '0));  // R9

endmodule

bind duo_slot_core duo_slot_core_chk #(.W(XLEN)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .pc         (pc_q),
   .br_taken   (br_taken),
   .br_target  (br_target),
   .ld_go      (ld_go),
   .ld_pend    (ld_pend_q),
   .probe_addr (host_rf_addr),
   .probe_data (host_rf_rdata)
);

// File: tb/duo_slot_core_tb.sv
module duo_slot_core_tb;
   timeunit 1ns;
   timeprecision 1ps;

   localparam int OP_ADDI = 8, OP_BEQ = 4, OP_BNE = 5, OP_LW = 35, OP_SW = 43;
   localparam int F_ADDU = 33, F_SUBU = 35, F_AND = 36, F_OR = 37, F_SLT = 42;
   localparam int NVEC = 25;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        imem_we;
   logic [5:0]  imem_addr;
   logic [63:0] imem_wdata;
   logic        host_dm_we;
   logic [5:0]  host_dm_addr;
   logic [31:0] host_dm_wdata, host_dm_rdata;
   logic [4:0]  host_rf_addr;
   logic [31:0] host_rf_rdata, pc_o;

   int n_chk = 0;
   int n_fail = 0;
   int cyc = 0;

   always #2.5 clk = ~clk;

   duo_slot_core u_dut (
      .clk           (clk),
      .rst_n         (rst_n),
      .imem_we       (imem_we),
      .imem_addr     (imem_addr),
      .imem_wdata    (imem_wdata),
      .host_dm_we    (host_dm_we),
      .host_dm_addr  (host_dm_addr),
      .host_dm_wdata (host_dm_wdata),
      .host_dm_rdata (host_dm_rdata),
      .host_rf_addr  (host_rf_addr),
      .host_rf_rdata (host_rf_rdata),
      .pc_o          (pc_o)
   );

   // result table: {kind 0=reg 1=mem, requirement, index, expected}
   localparam logic [47:0] VEC [NVEC] = '{
      {4'd0, 4'd3,  8'd1,  32'd5},        // R3 addi
      {4'd0, 4'd6,  8'd2,  32'd20},       // R6 load
      {4'd0, 4'd3,  8'd3,  32'hFFFFFFFD}, // R3 negative immediate
      {4'd0, 4'd7,  8'd4,  32'd0},        // R7 stale value next bundle
      {4'd0, 4'd6,  8'd5,  32'd30},       // R6 load
      {4'd0, 4'd7,  8'd6,  32'd25},       // R7 loaded value two bundles on
      {4'd0, 4'd3,  8'd7,  32'd8},        // R3 subtract
      {4'd0, 4'd3,  8'd8,  32'd24},       // R3 and
      {4'd0, 4'd3,  8'd9,  32'd31},       // R3 or
      {4'd0, 4'd3,  8'd10, 32'd1},        // R3 signed less-than true
      {4'd0, 4'd3,  8'd11, 32'd0},        // R3 signed less-than false
      {4'd0, 4'd8,  8'd12, 32'd0},        // R8 addi in memory slot
      {4'd0, 4'd8,  8'd13, 32'd0},        // R8 load in compute slot
      {4'd0, 4'd8,  8'd16, 32'd0},        // R8 unknown funct
      {4'd0, 4'd9,  8'd0,  32'd0},        // R9 writes to zero register
      {4'd0, 4'd3,  8'd14, 32'd1},        // R3 addi
      {4'd0, 4'd10, 8'd15, 32'd40},       // R10 load beats compute
      {4'd0, 4'd4,  8'd17, 32'd0},        // R4 skipped bundle
      {4'd0, 4'd4,  8'd18, 32'd7},        // R4 untaken branch falls through
      {4'd1, 4'd6,  8'd4,  32'd5},        // R6 store
      {4'd1, 4'd5,  8'd5,  32'd8},        // R5 store beside taken branch
      {4'd1, 4'd6,  8'd1,  32'd31},       // R6 negative offset store
      {4'd1, 4'd6,  8'd0,  32'd10},       // R6 untouched word
      {4'd1, 4'd6,  8'd2,  32'd30},       // R6 untouched word
      {4'd1, 4'd6,  8'd3,  32'd40}        // R6 untouched word
   };

   function automatic logic [31:0] rins(input int f, input int rs, input int rt, input int rd);
      return {6'd0, rs[4:0], rt[4:0], rd[4:0], 5'd0, f[5:0]};
   endfunction

   function automatic logic [31:0] iins(input int op, input int rs, input int rt, input int imm);
      return {op[5:0], rs[4:0], rt[4:0], imm[15:0]};
   endfunction

   task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   task automatic put_bundle(input int idx, input logic [31:0] s0, input logic [31:0] s1);
      imem_we    = 1'b1;
      imem_addr  = idx[5:0];
      imem_wdata = {s0, s1};
      @(negedge clk);
      imem_we    = 1'b0;
   endtask

   task automatic put_word(input int idx, input logic [31:0] val);
      host_dm_we    = 1'b1;
      host_dm_addr  = idx[5:0];
      host_dm_wdata = val;
      @(negedge clk);
      host_dm_we    = 1'b0;
   endtask

   task automatic read_reg(input int idx, output logic [31:0] v);
      host_rf_addr = idx[4:0];
      #1;
      v = host_rf_rdata;
   endtask

   task automatic read_mem(input int idx, output logic [31:0] v);
      host_dm_addr = idx[5:0];
      #1;
      v = host_dm_rdata;
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc > 100000) begin
         n_fail++;
         $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      logic [31:0] v;
      int k;
      rst_n = 1'b0; imem_we = 1'b0; imem_addr = '0; imem_wdata = '0;
      host_dm_we = 1'b0; host_dm_addr = '0; host_dm_wdata = '0; host_rf_addr = '0;
      repeat (2) @(negedge clk);

      // program A: operation coverage
      put_word(0, 32'd10); put_word(1, 32'd20); put_word(2, 32'd30); put_word(3, 32'd40);
      put_bundle(0,  iins(OP_ADDI, 0, 1, 5),    iins(OP_LW, 0, 2, 4));
      put_bundle(1,  rins(F_ADDU, 2, 0, 4),     iins(OP_LW, 0, 5, 8));
      put_bundle(2,  rins(F_ADDU, 2, 1, 6),     iins(OP_SW, 0, 1, 16));
      put_bundle(3,  iins(OP_ADDI, 0, 3, -3),   iins(OP_LW, 0, 0, 0));
      put_bundle(4,  rins(F_SUBU, 1, 3, 7),     32'd0);
      put_bundle(5,  rins(F_AND, 6, 5, 8),      32'd0);
      put_bundle(6,  rins(F_OR, 6, 5, 9),       32'd0);
      put_bundle(7,  rins(F_SLT, 3, 1, 10),     32'd0);
      put_bundle(8,  rins(F_SLT, 1, 3, 11),     iins(OP_ADDI, 0, 12, 77));
      put_bundle(9,  iins(OP_LW, 0, 13, 0),     32'd0);
      put_bundle(10, iins(OP_ADDI, 0, 0, 9),    32'd0);
      put_bundle(11, iins(OP_ADDI, 0, 14, 1),   iins(OP_LW, 0, 15, 12));
      put_bundle(12, iins(OP_ADDI, 0, 15, 99),  32'd0);
      put_bundle(13, rins(0, 1, 1, 16),         iins(15, 0, 16, 5));
      put_bundle(14, iins(OP_BEQ, 1, 1, 1),     iins(OP_SW, 0, 7, 20));
      put_bundle(15, iins(OP_ADDI, 0, 17, 1),   32'd0);
      put_bundle(16, iins(OP_BNE, 1, 1, 5),     32'd0);
      put_bundle(17, iins(OP_ADDI, 0, 18, 7),   iins(OP_SW, 7, 9, -4));
      put_bundle(18, iins(OP_BEQ, 0, 0, -1),    32'd0);

      #1;
      chk("R1", "pc in reset", pc_o, 32'd0);
      rst_n = 1'b1;
      for (int s = 1; s <= 3; s++) begin
         @(negedge clk); #1;
         chk("R2", "pc step", pc_o, 32'(8 * s));
      end
      repeat (40) @(negedge clk);

      for (int i = 0; i < NVEC; i++) begin
         if (VEC[i][47:44] == 4'd0) read_reg(int'(VEC[i][39:32]), v);
         else                       read_mem(int'(VEC[i][39:32]), v);
         chk($sformatf("R%0d", VEC[i][43:40]),
             $sformatf("%s %0d", (VEC[i][47:44] == 4'd0) ? "reg" : "mem", VEC[i][39:32]),
             v, VEC[i][31:0]);
      end
      chk("R4", "self-loop pc", pc_o, 32'd144);

      // R11: host write outside reset is ignored
      @(negedge clk);
      put_word(0, 32'hDEAD);
      read_mem(0, v);
      chk("R11", "host write while running", v, 32'd10);

      // R1: reset clears registers and fetch address
      @(negedge clk);
      rst_n = 1'b0;
      read_reg(1, v);
      chk("R1", "reg 1 in reset", v, 32'd0);
      chk("R1", "pc after reset", pc_o, 32'd0);

      // program B: scheduled array-add loop
      for (int i = 0; i < 8; i++) put_word(i, 32'(3 * i + 1));
      put_bundle(0, iins(OP_ADDI, 0, 1, 28),  32'd0);
      put_bundle(1, iins(OP_ADDI, 0, 2, 100), 32'd0);
      put_bundle(2, 32'd0,                    iins(OP_LW, 1, 3, 0));
      put_bundle(3, iins(OP_ADDI, 1, 1, -4),  32'd0);
      put_bundle(4, rins(F_ADDU, 3, 2, 3),    32'd0);
      put_bundle(5, iins(OP_BNE, 1, 0, -4),   iins(OP_SW, 1, 3, 4));
      put_bundle(6, iins(OP_BEQ, 0, 0, -1),   32'd0);
      rst_n = 1'b1;
      k = 0;
      #1;
      while (pc_o != 32'd48 && k < 500) begin
         @(negedge clk); #1;
         k++;
      end
      chk("R12", "loop cycles", 32'(k), 32'(2 + 4 * 7));
      repeat (4) @(negedge clk);
      for (int i = 0; i < 8; i++) begin
         read_mem(i, v);
         chk("R12", $sformatf("array word %0d", i), v, (i == 0) ? 32'd1 : 32'(3 * i + 1 + 100));
      end
      read_reg(1, v);
      chk("R12", "pointer at exit", v, 32'd0);

      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule